// File: doc/BRIEF.md
# Character-Column Horizontal Timing Generator

This block produces horizontal line timing for a character-based video path. The unit of time is one character column, and the line advances only on a character-clock enable. Three down-counters set the timing. A line-period counter reloads from the programmed total whenever it reaches zero. A sync counter is loaded at that same moment and keeps HSYNC high while it is non-zero. A display counter is loaded when the line-period counter equals the programmed sync position, and it keeps the display enable high while it is non-zero.

The display window is placed by an equality compare against the line-period counter. No up-counter is compared against thresholds. Downstream logic aligns to a one-clock line-start strobe. The sync position and displayed-column count are captured once per line, so a mid-line write cannot tear the current line. Vertical timing, pixel shifting and memory fetches belong to other blocks.

Top module: `chr_hsync_gen`

## Requirements
- R1: On an enabled character step with the line-period counter at zero, the counter reloads `cfg_total`; on any other enabled step it decrements by one. Consecutive line-start strobes are therefore `cfg_total`+1 enabled steps apart.
- R2: `line_start` is high for exactly one clock, in the clock that follows the reload step. Taking the clock in which it is high as column index 0, it stays low for indices 1 to `cfg_total`.
- R3: The sync counter loads the low 4 bits of `cfg_sync_wid` at the reload step, and `hsync` is high while that counter is non-zero. With the low 4 bits equal to W, `hsync` is high for column indices 0 to W-1 of each line. Bits 7:4 of `cfg_sync_wid` have no effect.
- R4: The display counter loads the captured displayed count D on the step at which the line-period counter equals the captured sync position P. `hdisp` is then high for D consecutive columns, beginning at index `cfg_total`-P+1. A window that runs past the end of the line continues at index 0 of the next line.
- R5: Without `char_en`, no counter changes, `hsync` and `hdisp` hold their values, and no `line_start` occurs. Enabling every other clock doubles the line period measured in clocks.
- R6: The sync and display counters stop at zero and do not wrap. A width of 0 gives no `hsync` in the line, and a displayed count of 0 gives no `hdisp`.
- R7: A change to `cfg_total`, `cfg_sync_pos`, `cfg_disp_cnt` or `cfg_sync_wid` made mid-line takes effect at the next reload, not during the current line.
- R8: While `rst_n` is low, all counters are zero and `hsync`, `hdisp` and `line_start` are low. The first enabled step after reset performs a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_en | input | 1 | One-clock enable per character column |
| cfg_total | input | CW | Line period minus one, in columns |
| cfg_sync_pos | input | CW | Line-period counter value that starts the display window |
| cfg_disp_cnt | input | CW | Number of displayed columns |
| cfg_sync_wid | input | CW | Sync width in columns; only the low 4 bits are used |
| hsync | output | 1 | Horizontal sync, active high |
| hdisp | output | 1 | Horizontal display enable |
| line_start | output | 1 | One-clock strobe at the start of each line |

## Verification
All counters are registered, so a counter loaded on an enabled clock edge shows its effect in the next clock. `hsync` rises in the clock in which `line_start` is high, which is column index 0. `hdisp` rises one column after the clock in which the line-period counter shows the sync position. The bench runs with `char_en` held high, counts columns from each observed `line_start`, and compares `hsync`, `hdisp` and `line_start` at every index on the falling edge, against values computed from `cfg_total`, P, D and W. Each check waits out two full lines after a configuration change, so every captured value and every display window carried over from the previous line has cleared before sampling starts.

// File: rtl/hzt_pkg.sv
package hzt_pkg;
  localparam int unsigned HZT_CW_DEF   = 8;
  localparam int unsigned HZT_SYNC_DEF = 4;

  typedef struct packed {
    logic hsync;
    logic hdisp;
    logic line_start;
  } hzt_out_t;
endpackage

// File: rtl/hzt_reload_ctr.sv
module hzt_reload_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         nonzero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step) begin
      if (load)                cnt_d = load_val;
      else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count   = cnt_q;
  assign nonzero = (cnt_q != '0);
endmodule

// File: rtl/chr_hsync_gen.sv
module chr_hsync_gen
  import hzt_pkg::*;
#(
  parameter int unsigned CW        = HZT_CW_DEF,
  parameter int unsigned SYNC_BITS = HZT_SYNC_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_en,
  input  logic [CW-1:0] cfg_total,
  input  logic [CW-1:0] cfg_sync_pos,
  input  logic [CW-1:0] cfg_disp_cnt,
  input  logic [CW-1:0] cfg_sync_wid,
  output logic          hsync,
  output logic          hdisp,
  output logic          line_start
);
  logic [CW-1:0]        tot_q, dsp_q, sh_pos, sh_disp, sh_pos_d, sh_disp_d;
  logic [SYNC_BITS-1:0] syn_q;
  logic                 tot_nz, syn_nz, dsp_nz;
  logic                 reload, disp_hit, ls_d, ls_q;
  hzt_out_t             outs;
  logic                 unused_wid;

  assign unused_wid = ^cfg_sync_wid[CW-1:SYNC_BITS];

  assign reload   = char_en & ~tot_nz;
  assign disp_hit = (tot_q == sh_pos);

  hzt_reload_ctr #(.W(CW)) u_total (
    .clk(clk), .rst_n(rst_n), .step(char_en), .load(~tot_nz),
    .load_val(cfg_total), .count(tot_q), .nonzero(tot_nz));

  hzt_reload_ctr #(.W(SYNC_BITS)) u_sync (
    .clk(clk), .rst_n(rst_n), .step(char_en), .load(~tot_nz),
    .load_val(cfg_sync_wid[SYNC_BITS-1:0]), .count(syn_q), .nonzero(syn_nz));

  hzt_reload_ctr #(.W(CW)) u_disp (
    .clk(clk), .rst_n(rst_n), .step(char_en), .load(disp_hit),
    .load_val(sh_disp), .count(dsp_q), .nonzero(dsp_nz));

  always_comb begin
    sh_pos_d  = sh_pos;
    sh_disp_d = sh_disp;
    ls_d      = reload;
    if (reload) begin
      sh_pos_d  = cfg_sync_pos;
      sh_disp_d = cfg_disp_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_pos  <= '0;
      sh_disp <= '0;
      ls_q    <= 1'b0;
    end else begin
      sh_pos  <= sh_pos_d;
      sh_disp <= sh_disp_d;
      ls_q    <= ls_d;
    end
  end

  always_comb begin
    outs.hsync      = syn_nz;
    outs.hdisp      = dsp_nz;
    outs.line_start = ls_q;
  end

  assign hsync      = outs.hsync;
  assign hdisp      = outs.hdisp;
  assign line_start = outs.line_start;
endmodule

// File: rtl/chr_hsync_gen_chk.sv
module chr_hsync_gen_chk #(
  parameter int unsigned CW = 8,
  parameter int unsigned SB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          char_en,
  input logic [CW-1:0] cfg_total,
  input logic [CW-1:0] cfg_sync_wid,
  input logic [CW-1:0] tot_q,
  input logic [SB-1:0] syn_q,
  input logic [CW-1:0] dsp_q,
  input logic [CW-1:0] sh_pos,
  input logic [CW-1:0] sh_disp,
  input logic          line_start
);
  a_r1_total_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (char_en && tot_q == '0) |=> (tot_q == $past(cfg_total)));

  a_r1_total_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (char_en && tot_q != '0) |=> (tot_q == $past(tot_q) - 1'b1));

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && tot_q != '0) |=> !line_start);

  a_r3_sync_load: assert property (@(posedge clk) disable iff (!rst_n)
    (char_en && tot_q == '0) |=> (syn_q == $past(cfg_sync_wid[SB-1:0])));

  a_r4_disp_load: assert property (@(posedge clk) disable iff (!rst_n)
    (char_en && tot_q == sh_pos) |=> (dsp_q == $past(sh_disp)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !char_en |=> ($stable(tot_q) && $stable(syn_q) && $stable(dsp_q) && !line_start));

  a_r6_sync_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (char_en && syn_q == '0 && tot_q != '0) |=> (syn_q == '0));

  a_r6_disp_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (char_en && dsp_q == '0 && tot_q != sh_pos) |=> (dsp_q == '0));
endmodule

bind chr_hsync_gen chr_hsync_gen_chk #(.CW(CW), .SB(SYNC_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .char_en(char_en), .cfg_total(cfg_total),
  .cfg_sync_wid(cfg_sync_wid), .tot_q(tot_q), .syn_q(syn_q), .dsp_q(dsp_q),
  .sh_pos(sh_pos), .sh_disp(sh_disp), .line_start(line_start));

// File: tb/test_chr_hsync_gen.sv
`timescale 1ns/1ps
module test_chr_hsync_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_all, en_half, phase;
  logic       char_en;
  logic [7:0] cfg_total, cfg_sync_pos, cfg_disp_cnt, cfg_sync_wid;
  logic       hsync, hdisp, line_start;
  int         total = 0;
  int         bad   = 0;
  int         cyc   = 0;

  // each entry: {total, sync_pos, disp_cnt, sync_wid_raw}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {8'd9,  8'd7,  8'd5,  8'h03},
    {8'd15, 8'd15, 8'd10, 8'h04},
    {8'd11, 8'd0,  8'd4,  8'h02},
    {8'd7,  8'd3,  8'd8,  8'h08},
    {8'd20, 8'd12, 8'd6,  8'h35},
    {8'd5,  8'd2,  8'd0,  8'h00}
  };

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    phase <= (rst_n === 1'b1) ? ~phase : 1'b0;
    cyc   <= cyc + 1;
    if (cyc > 100000) begin
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  assign char_en = en_all | (en_half & phase);

  chr_hsync_gen i_chr_hsync_gen (
    .clk(clk), .rst_n(rst_n), .char_en(char_en), .cfg_total(cfg_total),
    .cfg_sync_pos(cfg_sync_pos), .cfg_disp_cnt(cfg_disp_cnt),
    .cfg_sync_wid(cfg_sync_wid), .hsync(hsync), .hdisp(hdisp),
    .line_start(line_start));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns clocks until the next sampled line_start
  task automatic next_ls(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!line_start && n < 2000);
  endtask

  task automatic set_cfg(input logic [31:0] v);
    {cfg_total, cfg_sync_pos, cfg_disp_cnt, cfg_sync_wid} = v;
  endtask

  initial begin
    int n, n2, t, p, d, w, s, m;
    bit hs0, hd0, saw;
    rst_n = 1'b0; en_all = 1'b1; en_half = 1'b0; phase = 1'b0;
    set_cfg(VEC[0]);
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(!hsync && !hdisp && !line_start, "R8 reset outputs", {hsync, hdisp, line_start}, 0);
    rst_n = 1'b1;
    next_ls(n);
    chk(n == 1, "R8 first step reloads", n, 1);

    // vector table: check every column of a settled line
    foreach (VEC[i]) begin
      set_cfg(VEC[i]);
      t = VEC[i][31:24]; p = VEC[i][23:16]; d = VEC[i][15:8]; w = VEC[i][3:0];
      s = t - p + 1;
      next_ls(n); next_ls(n); next_ls(n);
      for (int k = 0; k <= t; k++) begin
        if (k > 0) @(negedge clk);
        m = (k + (t + 1) - s) % (t + 1);
        chk(line_start == (k == 0), "R2 strobe at index 0 only", line_start, k == 0);
        chk(hsync == (k < w), "R3 hsync column", hsync, k < w);
        chk(hdisp == (m < d), "R4 hdisp column", hdisp, m < d);
      end
      @(negedge clk);
      chk(line_start == 1'b1, "R1 period total+1", line_start, 1);
    end

    // R6: zero width / zero count give no pulse over a whole line
    set_cfg({8'd9, 8'd4, 8'd0, 8'hF0});
    next_ls(n); next_ls(n); next_ls(n);
    saw = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (k > 0) @(negedge clk);
      saw = saw | hsync | hdisp;
    end
    chk(!saw, "R6 zero width and count", saw, 0);

    // R7: mid-line total change applies at next reload
    set_cfg({8'd9, 8'd5, 8'd3, 8'h02});
    next_ls(n); next_ls(n);
    repeat (3) @(negedge clk);
    cfg_total = 8'd5;
    next_ls(n);
    chk(n + 3 == 10, "R7 current line keeps old total", n + 3, 10);
    next_ls(n);
    chk(n == 6, "R7 next line uses new total", n, 6);

    // R5: stall holds state
    repeat (2) @(negedge clk);
    en_all = 1'b0;
    @(negedge clk);
    hs0 = hsync; hd0 = hdisp; saw = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      saw = saw | line_start | (hsync != hs0) | (hdisp != hd0);
    end
    chk(!saw, "R5 stall holds outputs", saw, 0);

    // R5: half-rate enable doubles the period in clocks
    en_half = 1'b1;
    next_ls(n); next_ls(n); next_ls(n2);
    chk(n2 == 12, "R5 half-rate period", n2, 12);
    @(negedge clk);
    chk(!line_start, "R2 strobe one clock wide", line_start, 0);
    en_half = 1'b0; en_all = 1'b1;

    // R8: reset mid-line clears outputs
    set_cfg({8'd9, 8'd9, 8'd9, 8'h05});
    next_ls(n); next_ls(n);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!hsync && !hdisp && !line_start, "R8 reset mid-line", {hsync, hdisp, line_start}, 0);
    rst_n = 1'b1;
    next_ls(n);
    chk(n == 1, "R8 restart after reset", n, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule